// File: doc/BRIEF.md
# ALU Status Flag Unit

This block holds the four condition flags of a processor, Negative, Zero, Carry and Overflow, and works out their next values after every ALU operation. Each cycle it receives the class of the operation just performed, the ALU result, the raw carry bit from the adder or shifter, and the top bits of both operands. From these it computes the next flag set and writes it on the clock edge when the operation is marked valid.

A static two-bit policy input chooses how logical and register-load operations treat Carry and Overflow. The first setting clears both flags. The second clears Overflow only and keeps Carry. The third leaves every flag as it was. A separate enable makes shifts set Overflow to the exclusive-OR of the new Carry and the new Negative. With these settings one design can reproduce several established flag conventions.

The update strobe goes high for one cycle after each accepted operation.

Top module: `status_flag_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all four flags and the update strobe to 0.
- R2: Flags change only at an edge where valid is high; upd is high in the cycle after such an edge and low after any edge with valid low, and the flags then hold.
- R3: Operation class 3'b000 (add) sets N to result bit W-1, Z to 1 when the result is all zeros, C to carry_raw, and V to 1 exactly when a_msb equals b_msb and result bit W-1 differs from a_msb.
- R4: Operation class 3'b001 (subtract) sets N, Z and C as in R3, and V as in R3 with b_msb inverted before the comparison.
- R5: With policy 2'b00 or 2'b11, a logical (3'b010) or load (3'b100) operation sets N and Z from the result and writes C = 0 and V = 0.
- R6: With policy 2'b01, a logical or load operation sets N and Z from the result, writes V = 0 and keeps C at its previous value.
- R7: With policy 2'b10, a logical or load operation leaves all four flags unchanged.
- R8: Operation class 3'b011 (shift) under any policy sets N and Z from the result and C to carry_raw; V becomes C xor N of the new values when shift_ov_en is 1, and 0 when it is 0.
- R9: Operation classes 3'b101, 3'b110 and 3'b111 leave all four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Operation in this cycle updates the flags |
| op_class | input | 3 | Operation class code (see R3 to R9) |
| result | input | W | ALU result |
| a_msb | input | 1 | Most significant bit of operand A |
| b_msb | input | 1 | Most significant bit of operand B |
| carry_raw | input | 1 | Carry-out of the adder or shifter |
| policy | input | 2 | Flag policy for logical and load operations |
| shift_ov_en | input | 1 | Enables the shift overflow rule |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| upd | output | 1 | Flags were written at the previous edge |

## Verification
The bench goes after the signed overflow boundaries: 0x7FFF plus 1, 0x8000 minus 1, and subtracting equal-sign values. A design that forgot to invert b_msb on subtract would report overflow on the wrong side of these cases. It also places a logical operation right after a carry-setting add under each policy. A design that mixed up the policies would clear a Carry that should be kept, or it would touch flags that should hold. Shifts that produce a zero result and a set carry, with the overflow rule on and off, expose a V that is taken from stale values instead of the new ones. Idle cycles and reserved class codes between operations would show any flag that drifts without a valid update.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

  typedef enum logic [2:0] {
    OPC_ADD   = 3'b000,
    OPC_SUB   = 3'b001,
    OPC_LOGIC = 3'b010,
    OPC_SHIFT = 3'b011,
    OPC_LOAD  = 3'b100
  } op_class_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Signed overflow from sign bits; subtract inverts the second operand sign.
  function automatic logic sgn_ovf(input logic am, input logic bm,
                                   input logic rm, input logic is_sub);
    logic beff;
    beff = bm ^ is_sub;
    return (am == beff) && (rm != am);
  endfunction

endpackage

// File: rtl/flagu_arith.sv
module flagu_arith
  import flagu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] result,
  input  logic         a_msb,
  input  logic         b_msb,
  input  logic         carry_raw,
  input  logic         is_sub,
  output flags_t       ar
);
  localparam int MSB = W - 1;

  always_comb begin
    ar.n = result[MSB];
    ar.z = (result == '0);
    ar.c = carry_raw;
    ar.v = sgn_ovf(a_msb, b_msb, result[MSB], is_sub);
  end
endmodule

// File: rtl/flagu_policy.sv
module flagu_policy
  import flagu_pkg::*;
(
  input  logic [2:0] op_class,
  input  logic [1:0] policy,
  input  logic       shift_ov_en,
  input  flags_t     ar,
  input  flags_t     cur,
  output flags_t     nxt,
  output logic       keep_c_ev,
  output logic       hold_all_ev
);
  logic is_arith, is_lgld, is_shift;

  assign is_arith = (op_class == OPC_ADD) || (op_class == OPC_SUB);
  assign is_lgld  = (op_class == OPC_LOGIC) || (op_class == OPC_LOAD);
  assign is_shift = (op_class == OPC_SHIFT);

  assign keep_c_ev   = is_lgld && (policy == 2'b01);
  assign hold_all_ev = (is_lgld && (policy == 2'b10))
                     || !(is_arith || is_lgld || is_shift);

  always_comb begin
    nxt = cur;
    if (is_arith) begin
      nxt = ar;
    end else if (is_shift) begin
      nxt.n = ar.n;
      nxt.z = ar.z;
      nxt.c = ar.c;
      nxt.v = shift_ov_en ? (ar.c ^ ar.n) : 1'b0;
    end else if (is_lgld) begin
      case (policy)
        2'b01: begin
          nxt.n = ar.n;
          nxt.z = ar.z;
          nxt.c = cur.c;
          nxt.v = 1'b0;
        end
        2'b10: nxt = cur;
        default: begin
          nxt.n = ar.n;
          nxt.z = ar.z;
          nxt.c = 1'b0;
          nxt.v = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import flagu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic [2:0]   op_class,
  input  logic [W-1:0] result,
  input  logic         a_msb,
  input  logic         b_msb,
  input  logic         carry_raw,
  input  logic [1:0]   policy,
  input  logic         shift_ov_en,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v,
  output logic         upd
);
  flags_t cur_q, ar_w, nxt_w;
  logic   keep_c_ev, hold_all_ev;

  flagu_arith #(.W(W)) u_arith (
    .result    (result),
    .a_msb     (a_msb),
    .b_msb     (b_msb),
    .carry_raw (carry_raw),
    .is_sub    (op_class == OPC_SUB),
    .ar        (ar_w)
  );

  flagu_policy u_policy (
    .op_class    (op_class),
    .policy      (policy),
    .shift_ov_en (shift_ov_en),
    .ar          (ar_w),
    .cur         (cur_q),
    .nxt         (nxt_w),
    .keep_c_ev   (keep_c_ev),
    .hold_all_ev (hold_all_ev)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      upd   <= 1'b0;
    end else begin
      upd <= valid;
      if (valid) cur_q <= nxt_w;
    end
  end

  assign flag_n = cur_q.n;
  assign flag_z = cur_q.z;
  assign flag_c = cur_q.c;
  assign flag_v = cur_q.v;
endmodule

// File: rtl/flagu_checker.sv
module flagu_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         valid,
  input logic [2:0]   op_class,
  input logic [W-1:0] result,
  input logic         carry_raw,
  input logic [1:0]   policy,
  input logic         shift_ov_en,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_c,
  input logic         flag_v,
  input logic         upd,
  input logic         keep_c_ev,
  input logic         hold_all_ev
);
  logic [3:0] f;
  logic       lgld;
  assign f    = {flag_n, flag_z, flag_c, flag_v};
  assign lgld = (op_class == 3'b010) || (op_class == 3'b100);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (f == 4'b0000) && !upd);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(f) && !upd);

  p_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    valid |=> upd);

  p_arith_carry_r3: assert property (@(posedge clk) disable iff (rst)
    valid && (op_class == 3'b000) |=> flag_c == $past(carry_raw)
                                     && flag_z == ($past(result) == '0));

  p_clear_both_r5: assert property (@(posedge clk) disable iff (rst)
    valid && lgld && (policy == 2'b00 || policy == 2'b11) |=> !flag_c && !flag_v);

  p_keep_carry_r6: assert property (@(posedge clk) disable iff (rst)
    valid && keep_c_ev |=> !flag_v && flag_c == $past(flag_c));

  p_hold_all_r7: assert property (@(posedge clk) disable iff (rst)
    valid && hold_all_ev |=> $stable(f));

  p_shift_ovf_r8: assert property (@(posedge clk) disable iff (rst)
    valid && (op_class == 3'b011) && shift_ov_en |=> flag_v == (flag_c ^ flag_n));

  p_shift_noovf_r8: assert property (@(posedge clk) disable iff (rst)
    valid && (op_class == 3'b011) && !shift_ov_en |=> !flag_v);

  p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
    valid && (op_class > 3'b100) |=> $stable(f));
endmodule

bind status_flag_unit flagu_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .valid       (valid),
  .op_class    (op_class),
  .result      (result),
  .carry_raw   (carry_raw),
  .policy      (policy),
  .shift_ov_en (shift_ov_en),
  .flag_n      (flag_n),
  .flag_z      (flag_z),
  .flag_c      (flag_c),
  .flag_v      (flag_v),
  .upd         (upd),
  .keep_c_ev   (keep_c_ev),
  .hold_all_ev (hold_all_ev)
);

// File: tb/status_flag_unit_test.sv
`timescale 1ns/1ps
module status_flag_unit_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst, valid, a_msb, b_msb, carry_raw, shift_ov_en;
  logic [2:0]   op_class;
  logic [W-1:0] result;
  logic [1:0]   policy;
  logic         flag_n, flag_z, flag_c, flag_v, upd;

  int checks = 0;
  int fails  = 0;

  // expected model state
  logic en, ez, ec, ev;

  always #2 clk = ~clk;

  status_flag_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .valid(valid), .op_class(op_class), .result(result),
    .a_msb(a_msb), .b_msb(b_msb), .carry_raw(carry_raw), .policy(policy),
    .shift_ov_en(shift_ov_en), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .upd(upd)
  );

  function automatic string req_of(input logic [2:0] oc, input logic [1:0] pol, input logic vld);
    if (!vld) return "R2";
    case (oc)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd3: return "R8";
      3'd2, 3'd4: return (pol == 2'd1) ? "R6" : (pol == 2'd2) ? "R7" : "R5";
      default: return "R9";
    endcase
  endfunction

  function automatic logic ovf_model(input logic [W-1:0] a, input logic [W-1:0] b,
                                     input logic [W-1:0] r, input logic sub);
    logic sa, sb, sr;
    sa = a[W-1]; sb = b[W-1]; sr = r[W-1];
    if (sub) return (sa != sb) && (sr != sa);
    return (sa == sb) && (sr != sa);
  endfunction

  task automatic check(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {flag_n, flag_z, flag_c, flag_v, upd};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s nzcv_upd actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Apply one operation, clock it, and compare against the model.
  task automatic step(input logic vld, input logic [2:0] oc, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic [1:0] pol, input logic sen,
                      input logic [W-1:0] r, input logic cy);
    logic rn, rz, rv;
    valid = vld; op_class = oc; result = r; a_msb = a[W-1]; b_msb = b[W-1];
    carry_raw = cy; policy = pol; shift_ov_en = sen;
    rn = r[W-1]; rz = (r == 0);
    @(posedge clk);
    #1;
    if (vld) begin
      case (oc)
        3'd0, 3'd1: begin
          rv = ovf_model(a, b, r, oc == 3'd1);
          en = rn; ez = rz; ec = cy; ev = rv;
        end
        3'd3: begin
          en = rn; ez = rz; ec = cy; ev = sen ? (cy ^ rn) : 1'b0;
        end
        3'd2, 3'd4: begin
          if (pol == 2'd1) begin en = rn; ez = rz; ev = 1'b0; end
          else if (pol != 2'd2) begin en = rn; ez = rz; ec = 1'b0; ev = 1'b0; end
        end
        default: ;
      endcase
    end
    check(req_of(oc, pol, vld), {en, ez, ec, ev, vld});
  endtask

  task automatic do_add(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] pol);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    step(1'b1, 3'd0, a, b, pol, 1'b0, s[W-1:0], s[W]);
  endtask

  task automatic do_sub(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] pol);
    logic [W-1:0] d;
    d = a - b;
    step(1'b1, 3'd1, a, b, pol, 1'b0, d, a >= b);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; valid = 1'b0; op_class = '0; result = '0; a_msb = 0; b_msb = 0;
    carry_raw = 1'b1; policy = '0; shift_ov_en = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    en = 0; ez = 0; ec = 0; ev = 0;
    check("R1", 5'b00000);
    rst = 1'b0;

    // R3 overflow boundary: 0x7FFF + 1
    do_add(16'h7FFF, 16'h0001, 2'd0);
    // R3 carry and zero: 0xFFFF + 1
    do_add(16'hFFFF, 16'h0001, 2'd0);
    // R4 overflow boundary: 0x8000 - 1
    do_sub(16'h8000, 16'h0001, 2'd0);
    // R4 equal signs, no overflow
    do_sub(16'h8000, 16'h8000, 2'd0);
    // R6 carry kept after carry-setting add
    do_add(16'hFFFF, 16'h0002, 2'd1);
    step(1'b1, 3'd2, 16'h0, 16'h0, 2'd1, 1'b0, 16'h8001, 1'b0);
    step(1'b1, 3'd4, 16'h0, 16'h0, 2'd1, 1'b0, 16'h0000, 1'b0);
    // R7 nothing changes
    do_add(16'h7FFF, 16'h7FFF, 2'd2);
    step(1'b1, 3'd2, 16'h0, 16'h0, 2'd2, 1'b0, 16'h0000, 1'b1);
    // R5 clears carry and overflow, also with policy 11
    do_add(16'hFFFF, 16'h8000, 2'd0);
    step(1'b1, 3'd2, 16'h0, 16'h0, 2'd0, 1'b0, 16'h0000, 1'b1);
    do_add(16'hFFFF, 16'h8000, 2'd3);
    step(1'b1, 3'd4, 16'h0, 16'h0, 2'd3, 1'b0, 16'hF000, 1'b1);
    // R8 shift with overflow rule on and off
    step(1'b1, 3'd3, 16'h0, 16'h0, 2'd2, 1'b1, 16'h0000, 1'b1);
    step(1'b1, 3'd3, 16'h0, 16'h0, 2'd0, 1'b1, 16'h8000, 1'b1);
    step(1'b1, 3'd3, 16'h0, 16'h0, 2'd1, 1'b0, 16'h8000, 1'b0);
    // R9 reserved classes, R2 idle cycles
    do_add(16'h4000, 16'h4000, 2'd0);
    step(1'b1, 3'd5, 16'h0, 16'h0, 2'd0, 1'b0, 16'h0000, 1'b0);
    step(1'b1, 3'd7, 16'h0, 16'h0, 2'd0, 1'b1, 16'h0000, 1'b1);
    step(1'b0, 3'd0, 16'h0, 16'h0, 2'd0, 1'b0, 16'h0000, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] a, b, r;
      logic [2:0] oc;
      a = W'($urandom); b = W'($urandom);
      if ((i % 7) == 0) a = 16'h8000;
      if ((i % 11) == 0) b = 16'h7FFF;
      oc = 3'($urandom_range(0, 7));
      r = W'($urandom);
      if ((i % 5) == 0) r = '0;
      if (oc == 3'd0 && ($urandom % 8) != 0) do_add(a, b, 2'($urandom));
      else if (oc == 3'd1 && ($urandom % 8) != 0) do_sub(a, b, 2'($urandom));
      else step(($urandom % 6) != 0, oc, a, b, 2'($urandom), 1'($urandom),
                r, 1'($urandom));
    end

    // R1 reset mid-run after flags are set
    do_add(16'hFFFF, 16'h8000, 2'd0);
    rst = 1'b1; valid = 1'b1;
    @(posedge clk); #1;
    en = 0; ez = 0; ec = 0; ev = 0;
    check("R1", 5'b00000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule